// File: doc/BRIEF.md
# Edge-Retriggered Serial Response Receiver

This block receives the 64-bit status word that a game pad sends back over a single shared, idle-high data line after the console has polled it. Each reply bit starts with the line falling low. A '0' then stays low for about three quarters of the bit time, and a '1' stays low for about one quarter. The receiver has no free-running bit clock. It re-aligns on every falling edge and starts a one-shot delay timer there. When the timer expires, about 2 microseconds after the edge, it takes one sample of the line, and that level is the bit value.

The receiver ignores the line until the poll transmitter signals that its command frame has finished. The first falling edge after that signal starts the reply. Sixty-four bits are shifted in, first bit into the most significant position. The finished word is then copied into a status register that the host reads, and a ready flag is raised. The terminating stop bit is not stored.

If the line goes quiet partway through a reply, a gap watchdog discards the partial word and returns the receiver to idle. In that case the status register and the ready flag are left untouched. The status word layout, most significant byte first, is as follows:
- [63:56]: three zero bits, then the Start, Y, X, B and A buttons.
- [55:48]: a one bit, then the L, R, Z, Up, Down, Right and Left buttons.
- Lower six bytes: main stick X, main stick Y, second stick X, second stick Y, left trigger analog value and right trigger analog value.

Top module: `pad_reply_rx`

## Requirements
- R1: After reset, `ready` is 0 and `rd_data` is all zeros.
- R2: Falling edges on `line_in` have no effect unless the receiver was armed by a one-cycle `tx_done` pulse. After a reply completes or is aborted, edges are again ignored until the next `tx_done`.
- R3: Each bit value is the level of the synchronized line `SAMPLE_US` microseconds (`CYCLES_PER_US * SAMPLE_US` cycles) after that bit's falling edge, with exactly one sample per edge. A bit held low for 3 µs and then high for 1 µs reads as 0. A bit held low for 1 µs and then high for 3 µs reads as 1.
- R4: The first received bit lands in `rd_data[63]` and the 64th in `rd_data[0]`.
- R5: The stop bit that follows the 64th bit, and any edges after it, leave `rd_data` unchanged.
- R6: `rd_data` changes only on completion of a 64-bit reply. It takes the new word, and `ready` goes to 1, at the clock edge on which the 64th sample is taken. That edge is `CYCLES_PER_US * SAMPLE_US + 2` clock edges after the first edge that sees the last bit's falling level on `line_in`.
- R7: A one-cycle `rd_en` pulse clears `ready` on the next edge and leaves `rd_data` unchanged.
- R8: If `rd_en` is high in the same cycle in which a reply completes, `ready` is 1 afterwards.
- R9: While receiving, if no falling edge arrives for `TIMEOUT_US` microseconds, the partial reply is discarded and the receiver returns to idle. `ready` and `rd_data` keep their previous values, and the next armed reply is received intact.
- R10: An armed receiver waits for the first edge without any time limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_done | input | 1 | One-cycle pulse from the poll transmitter marking the end of its command frame |
| line_in | input | 1 | Asynchronous serial data line, idle high |
| rd_en | input | 1 | One-cycle host read strobe that clears `ready` |
| rd_data | output | 64 | Last completed status word |
| ready | output | 1 | Set when a new status word is available, cleared by a host read |

## Verification
Two functions can land on the same clock edge: the completion of a reply, which sets `ready`, and a host read, which clears it. The bench counts clock cycles from the falling edge of the final data bit and raises `rd_en` exactly in the cycle in which the 64th sample is taken. One cycle earlier it confirms that `ready` is still low. It then requires `ready` to be high, with the new word on `rd_data`, so that completion is seen to win over the read.

// File: rtl/pad_reply_rx_pkg.sv
package pad_reply_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RECV  = 2'd2
    } rx_state_e;

endpackage

// File: rtl/prx_line_sync.sv
module prx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_s,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.chain = {r_q.chain[STAGES-2:0], line_async};
        r_d.prev  = r_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.chain <= '1;
            r_q.prev  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign line_s = r_q.chain[STAGES-1];
    assign fall   = r_q.prev & ~line_s;

    // a detected edge cannot repeat on the following cycle
    p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/prx_oneshot.sv
module prx_oneshot #(
    parameter int DELAY = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic cancel,
    output logic fire
);
    localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } regs_t;

    regs_t r_d, r_q;

    assign fire = r_q.active && (r_q.cnt == LAST);

    always_comb begin
        r_d = r_q;
        if (restart) begin
            r_d.active = 1'b1;
            r_d.cnt    = '0;
        end else if (cancel) begin
            r_d.active = 1'b0;
            r_d.cnt    = '0;
        end else if (r_q.active) begin
            if (r_q.cnt == LAST) begin
                r_d.active = 1'b0;
                r_d.cnt    = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.active <= 1'b0;
            r_q.cnt    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // one trigger per edge: no second fire without a new restart
    p_single_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !restart) |=> !fire);
    p_restart_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !fire);
endmodule

// File: rtl/prx_gap_watch.sv
module prx_gap_watch #(
    parameter int LIMIT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } regs_t;

    regs_t r_d, r_q;

    assign expired = run && !kick && (r_q.cnt == LAST);

    always_comb begin
        r_d = r_q;
        if (!run || kick) begin
            r_d.cnt = '0;
        end else if (r_q.cnt != LAST) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // an edge always buys a full window before expiry
    p_kick_defers_r9: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !expired);
endmodule

// File: rtl/prx_shifter.sv
module prx_shifter #(
    parameter int NBITS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic             done,
    output logic [NBITS-1:0] status
);
    localparam int CNTW = $clog2(NBITS);
    localparam logic [CNTW-1:0] LAST = CNTW'(NBITS - 1);

    typedef struct packed {
        logic [NBITS-1:0] shreg;
        logic [CNTW-1:0]  cnt;
        logic [NBITS-1:0] status;
    } regs_t;

    regs_t r_d, r_q;

    assign done   = shift_en && !clear && (r_q.cnt == LAST);
    assign status = r_q.status;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.shreg = '0;
            r_d.cnt   = '0;
        end else if (shift_en) begin
            r_d.shreg = {r_q.shreg[NBITS-2:0], bit_in};
            if (r_q.cnt == LAST) begin
                r_d.status = {r_q.shreg[NBITS-2:0], bit_in};
                r_d.cnt    = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.shreg  <= '0;
            r_q.cnt    <= '0;
            r_q.status <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // published word moves only on a completed reply
    p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(status));
    p_clear_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !done);
endmodule

// File: rtl/pad_reply_rx.sv
module pad_reply_rx
    import pad_reply_rx_pkg::*;
#(
    parameter int CYCLES_PER_US = 50,
    parameter int SAMPLE_US     = 2,
    parameter int TIMEOUT_US    = 10,
    parameter int NBITS         = 64,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_done,
    input  logic             line_in,
    input  logic             rd_en,
    output logic [NBITS-1:0] rd_data,
    output logic             ready
);
    localparam int SAMPLE_CYC = CYCLES_PER_US * SAMPLE_US;
    localparam int GAP_CYC    = CYCLES_PER_US * TIMEOUT_US;

    typedef struct packed {
        rx_state_e state;
        logic      ready;
    } regs_t;

    regs_t r_d, r_q;

    logic line_s, line_fall;
    logic sample_fire, shift_en, rx_done, gap_expired;
    logic timer_restart, timer_cancel, rx_clear, gap_run;

    prx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (line_in),
        .line_s     (line_s),
        .fall       (line_fall)
    );

    prx_oneshot #(.DELAY(SAMPLE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (timer_restart),
        .cancel  (timer_cancel),
        .fire    (sample_fire)
    );

    prx_gap_watch #(.LIMIT(GAP_CYC)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (gap_run),
        .kick    (line_fall),
        .expired (gap_expired)
    );

    prx_shifter #(.NBITS(NBITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rx_clear),
        .shift_en (shift_en),
        .bit_in   (line_s),
        .done     (rx_done),
        .status   (rd_data)
    );

    always_comb begin
        timer_restart = line_fall && (r_q.state != ST_IDLE);
        timer_cancel  = (r_q.state == ST_IDLE);
        shift_en      = sample_fire && (r_q.state == ST_RECV);
        rx_clear      = (r_q.state != ST_RECV);
        gap_run       = (r_q.state == ST_RECV);
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (tx_done) r_d.state = ST_ARMED;
            end
            ST_ARMED: begin
                if (line_fall) r_d.state = ST_RECV;
            end
            ST_RECV: begin
                if (rx_done || gap_expired) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (rx_done) begin
            r_d.ready = 1'b1;
        end else if (rd_en) begin
            r_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.ready <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready = r_q.ready;

    p_idle_no_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE) |-> !shift_en);
    p_ready_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(rx_done));
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rx_done) |=> !ready);
    p_done_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> ready);
    p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_expired && !ready) |=> (!ready && $stable(rd_data)));
    p_armed_waits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ARMED) |-> !gap_expired);
endmodule

// File: tb/pad_reply_rx_test.sv
`timescale 1ns/1ps
module pad_reply_rx_test;
    localparam int US = 50;
    localparam int D  = 2 * US;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_done = 1'b0;
    logic        line_in = 1'b1;
    logic        rd_en = 1'b0;
    logic [63:0] rd_data;
    logic        ready;
    logic        mon_on = 1'b0;
    logic [63:0] exp_q[$];
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    pad_reply_rx uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_done (tx_done),
        .line_in (line_in),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .ready   (ready)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tx_done();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); line_in = 1'b0;
        repeat (b ? US : 3 * US) @(negedge clk);
        line_in = 1'b1;
        repeat (b ? 3 * US - 1 : US - 1) @(negedge clk);
    endtask

    task automatic send_bits(input logic [63:0] w, input int n);
        for (int i = 0; i < n; i++) send_bit(w[63 - i]);
    endtask

    task automatic send_reply(input logic [63:0] w);
        exp_q.push_back(w);
        send_bits(w, 64);
        send_bit(1'b1);
        idle(5 * US);
    endtask

    task automatic send_frame(input logic [63:0] w);
        pulse_tx_done();
        idle(2 * US);
        send_reply(w);
    endtask

    // scoreboard monitor: pops one expected word per ready
    initial begin
        logic [63:0] e;
        forever begin
            @(negedge clk);
            if (mon_on && ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 ready without a sent reply", {63'd0, ready}, 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R3 R4 received word", rd_data, e);
                end
                e = rd_data;
                rd_en = 1'b1;
                @(negedge clk);
                rd_en = 1'b0;
                chk(ready == 1'b0, "R7 read clears ready", {63'd0, ready}, 64'd0);
                chk(rd_data == e, "R7 read keeps data", rd_data, e);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    localparam logic [63:0] W_A = 64'h1AC3_807F_11EE_00FF;
    localparam logic [63:0] W_B = 64'h1FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] W_C = 64'h0AAA_5555_A55A_0FF0;
    localparam logic [63:0] W_D = 64'h0580_7F81_3366_9C01;
    localparam logic [63:0] W_E = 64'h1081_0000_FFFF_1234;
    localparam logic [63:0] W_F = 64'h0DF0_8877_6655_C3A5;

    initial begin
        idle(5);
        // R1 reset state
        chk(ready == 1'b0, "R1 ready after reset", {63'd0, ready}, 64'd0);
        chk(rd_data == 64'd0, "R1 data after reset", rd_data, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        idle(5);
        mon_on = 1'b1;

        // R2 edges before any tx_done are ignored
        send_bits(W_A, 8);
        idle(15 * US);
        chk(ready == 1'b0, "R2 unarmed edges ignored", {63'd0, ready}, 64'd0);
        chk(rd_data == 64'd0, "R2 unarmed data untouched", rd_data, 64'd0);

        // R3 R4 three distinct patterns
        send_frame(W_A);
        send_frame(W_B);
        send_frame(W_C);
        idle(5 * US);

        // R5 stop bit not stored
        chk(rd_data == W_C, "R5 stop bit not stored", rd_data, W_C);
        chk(ready == 1'b0, "R5 no ready from stop bit", {63'd0, ready}, 64'd0);

        // R2 edges after completion ignored until next tx_done
        send_bits(W_B, 10);
        idle(15 * US);
        chk(ready == 1'b0, "R2 post-completion edges ignored", {63'd0, ready}, 64'd0);
        chk(rd_data == W_C, "R2 post-completion data kept", rd_data, W_C);

        // R9 gap timeout aborts a partial reply
        pulse_tx_done();
        idle(2 * US);
        send_bits(W_B, 20);
        idle(15 * US);
        chk(ready == 1'b0, "R9 abort leaves ready low", {63'd0, ready}, 64'd0);
        chk(rd_data == W_C, "R9 abort keeps data", rd_data, W_C);
        send_frame(W_D);   // R9 next reply intact
        idle(5 * US);
        chk(exp_q.size() == 0, "R9 reply after abort delivered", 64'(exp_q.size()), 64'd0);

        // R10 armed receiver waits past the gap timeout
        pulse_tx_done();
        idle(30 * US);
        send_reply(W_E);
        idle(5 * US);
        chk(exp_q.size() == 0, "R10 late reply delivered", 64'(exp_q.size()), 64'd0);

        // R8 completion and read in the same cycle
        mon_on = 1'b0;
        pulse_tx_done();
        idle(2 * US);
        send_bits(W_F, 63);
        @(negedge clk); line_in = 1'b0;
        repeat (US) @(negedge clk);
        line_in = 1'b1;
        repeat (D + 2 - US) @(negedge clk);
        chk(ready == 1'b0, "R6 ready not early", {63'd0, ready}, 64'd0);
        chk(rd_data == W_E, "R6 data not early", rd_data, W_E);
        rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk(ready == 1'b1, "R8 completion wins over read", {63'd0, ready}, 64'd1);
        chk(rd_data == W_F, "R6 data on completion edge", rd_data, W_F);
        rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk(ready == 1'b0, "R7 later read clears", {63'd0, ready}, 64'd0);
        idle(US);
        send_bit(1'b1);
        idle(5 * US);
        mon_on = 1'b1;

        chk(exp_q.size() == 0, "R4 all replies consumed", 64'(exp_q.size()), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule